// File: doc/BRIEF.md
# Password Presentation Sequencer for a Serial-Bus Target

This block decides whether a master on a two-wire serial bus has presented the correct 32-bit password. It sits behind a bit-level front end, which reports start conditions, stop conditions and completed bytes as single-cycle events. With each stop the front end also reports whether the stop fell in the slot just after an acknowledge. The sequencer follows the expected frame byte by byte and raises an acknowledge request for every byte it accepts. It keeps both copies of the password that the frame carries.

A frame is valid when it has a select byte, a two-byte command address, the password, a validation byte and the password again. The block then waits for the stop. If that stop lands in the slot after the final acknowledge and the two copies agree, a timed internal cycle begins. For its whole length the block asserts `busy`, which also disables the SDA driver, and it ignores the bus. At the end of the cycle `unlocked` takes the result of comparing the received password with the stored reference. It keeps that value until a later cycle completes.

Top module: `pwd_present_seq`

## Requirements
- R1: After a synchronous reset, `ack_req`, `busy` and `unlocked` are all 0.
- R2: After a start, the accepted byte order is: select byte 8'hAE, then 8'h09, then 8'h00, four password bytes, validation byte 8'h09, and four more password bytes. In the select byte, bit 3 is the chip-enable (1) and bit 0 is the read/write flag (0). `ack_req` is high for exactly the cycle after each accepted byte event.
- R3: A byte that does not match its expected value is not acknowledged. This covers a wrong select, a wrong address or a wrong validation code. The sequence goes back to idle, and later bytes are not acknowledged until a new start. `unlocked` does not change.
- R4: Each password copy arrives most significant byte first. The first byte becomes bits 31:24.
- R5: If the two received copies differ in any bit, a qualified stop does not start the cycle and `unlocked` does not change.
- R6: The cycle starts only on a stop that is flagged as lying in the slot after the final acknowledge, with the whole frame received. Any other stop returns the sequencer to idle without starting the cycle.
- R7: `busy` goes high in the cycle after the starting stop and stays high for exactly WR_CYCLES clock cycles.
- R8: While `busy` is high, start, stop and byte events are all ignored. No byte is acknowledged, and the sequencer is idle when `busy` drops.
- R9: When `busy` drops, `unlocked` becomes 1 if the received password equals `pw_stored`, and 0 otherwise. At no other time does it change.
- R10: A start during a frame restarts the sequence at the select stage. Bytes captured before it are discarded.
- R11: A byte that arrives after the second password copy is not acknowledged. It returns the sequencer to idle, so a following stop starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated-start event (one cycle) |
| ev_stop | input | 1 | Stop event (one cycle) |
| stop_in_slot | input | 1 | Qualifies `ev_stop`: the stop fell in the slot right after an acknowledge |
| ev_byte | input | 1 | A byte has been received (one cycle) |
| byte_in | input | 8 | Received byte, valid with `ev_byte` |
| pw_stored | input | 8*PW_BYTES | Stored reference password |
| ack_req | output | 1 | Request to acknowledge the byte just received |
| busy | output | 1 | Internal cycle running; SDA disabled and bus ignored |
| unlocked | output | 1 | Write access to protected sectors granted |

## Verification
The bench targets stops that are almost right. One comes with the slot flag clear, one arrives after an extra byte, and one follows copies that differ in a single bit. A design that checks only the state, or only the flag, would start a cycle and change `unlocked` in one of these cases. Other tests send a byte-reversed password and a validation code that is off by one. Further tests inject a start and a select byte while `busy` is high, then send an address byte without a start. A sequencer that listens during the cycle would acknowledge one of these bytes. The bench also measures the length of `busy` to catch an off-by-one in the down-counter.

// File: rtl/pwd_present_pkg.sv
package pwd_present_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADR_HI,
    ST_ADR_LO,
    ST_PW1,
    ST_VAL,
    ST_PW2,
    ST_END
  } seq_state_e;

endpackage

// File: rtl/pwd_frame_tracker.sv
module pwd_frame_tracker
  import pwd_present_pkg::*;
#(
  parameter logic [7:0] SEL_CODE = 8'hAE,
  parameter logic [7:0] ADR_HI   = 8'h09,
  parameter logic [7:0] ADR_LO   = 8'h00,
  parameter logic [7:0] VAL_CODE = 8'h09,
  parameter int         PW_BYTES = 4,
  localparam int        PW_W     = 8 * PW_BYTES,
  localparam int        IDX_W    = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            stop_in_slot,
  input  logic            ev_byte,
  input  logic [7:0]      byte_in,
  output logic            ack_req,
  output logic            launch,
  output logic [PW_W-1:0] pw_out
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PW_BYTES - 1);

  seq_state_e      state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [PW_W-1:0] copy_a_q, copy_b_q;
  logic            ack_q;
  logic            take, sh_a, sh_b, clr;
  logic            last;

  assign last = (idx_q == LAST_IDX);

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    take    = 1'b0;
    launch  = 1'b0;
    sh_a    = 1'b0;
    sh_b    = 1'b0;
    clr     = 1'b0;
    if (!busy) begin
      if (ev_start) begin
        state_n = ST_SEL;
        idx_n   = '0;
        clr     = 1'b1;
      end else if (ev_stop) begin
        state_n = ST_IDLE;
        launch  = (state_q == ST_END) && stop_in_slot && (copy_a_q == copy_b_q);
      end else if (ev_byte) begin
        state_n = ST_IDLE;
        case (state_q)
          ST_SEL: begin
            if (byte_in == SEL_CODE) begin
              take    = 1'b1;
              state_n = ST_ADR_HI;
            end
          end
          ST_ADR_HI: begin
            if (byte_in == ADR_HI) begin
              take    = 1'b1;
              state_n = ST_ADR_LO;
            end
          end
          ST_ADR_LO: begin
            if (byte_in == ADR_LO) begin
              take    = 1'b1;
              state_n = ST_PW1;
              idx_n   = '0;
            end
          end
          ST_PW1: begin
            take = 1'b1;
            sh_a = 1'b1;
            if (last) begin
              state_n = ST_VAL;
              idx_n   = '0;
            end else begin
              state_n = ST_PW1;
              idx_n   = idx_q + IDX_W'(1);
            end
          end
          ST_VAL: begin
            if (byte_in == VAL_CODE) begin
              take    = 1'b1;
              state_n = ST_PW2;
              idx_n   = '0;
            end
          end
          ST_PW2: begin
            take = 1'b1;
            sh_b = 1'b1;
            if (last) begin
              state_n = ST_END;
              idx_n   = '0;
            end else begin
              state_n = ST_PW2;
              idx_n   = idx_q + IDX_W'(1);
            end
          end
          default: state_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      copy_a_q <= '0;
      copy_b_q <= '0;
      ack_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      ack_q   <= take;
      if (clr) begin
        copy_a_q <= '0;
        copy_b_q <= '0;
      end else begin
        if (sh_a) copy_a_q <= {copy_a_q[PW_W-9:0], byte_in};
        if (sh_b) copy_b_q <= {copy_b_q[PW_W-9:0], byte_in};
      end
    end
  end

  assign ack_req = ack_q;
  assign pw_out  = copy_a_q;

endmodule

// File: rtl/pwd_cycle_timer.sv
module pwd_cycle_timer #(
  parameter int WR_CYCLES = 250000,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end else if (launch) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES);
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pwd_access_gate.sv
module pwd_access_gate #(
  parameter int PW_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            done,
  input  logic [PW_W-1:0] pw_rx,
  input  logic [PW_W-1:0] pw_ref,
  output logic            unlocked
);

  logic match_q;
  logic unl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      unl_q   <= 1'b0;
    end else begin
      match_q <= (pw_rx == pw_ref);
      if (done) unl_q <= match_q;
    end
  end

  assign unlocked = unl_q;

endmodule

// File: rtl/pwd_present_seq.sv
module pwd_present_seq #(
  parameter logic [7:0] SEL_CODE  = 8'hAE,
  parameter logic [7:0] ADR_HI    = 8'h09,
  parameter logic [7:0] ADR_LO    = 8'h00,
  parameter logic [7:0] VAL_CODE  = 8'h09,
  parameter int         PW_BYTES  = 4,
  parameter int         WR_CYCLES = 250000,
  localparam int        PW_W      = 8 * PW_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            stop_in_slot,
  input  logic            ev_byte,
  input  logic [7:0]      byte_in,
  input  logic [PW_W-1:0] pw_stored,
  output logic            ack_req,
  output logic            busy,
  output logic            unlocked
);

  logic            launch;
  logic            done;
  logic [PW_W-1:0] pw_rx;

  pwd_frame_tracker #(
    .SEL_CODE (SEL_CODE),
    .ADR_HI   (ADR_HI),
    .ADR_LO   (ADR_LO),
    .VAL_CODE (VAL_CODE),
    .PW_BYTES (PW_BYTES)
  ) u_track (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .stop_in_slot (stop_in_slot),
    .ev_byte      (ev_byte),
    .byte_in      (byte_in),
    .ack_req      (ack_req),
    .launch       (launch),
    .pw_out       (pw_rx)
  );

  pwd_cycle_timer #(
    .WR_CYCLES (WR_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  pwd_access_gate #(
    .PW_W (PW_W)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .pw_rx    (pw_rx),
    .pw_ref   (pw_stored),
    .unlocked (unlocked)
  );

endmodule

// File: rtl/pwd_present_seq_chk.sv
module pwd_present_seq_chk #(
  parameter int WR_CYCLES = 250000
) (
  input logic clk,
  input logic rst,
  input logic ev_stop,
  input logic stop_in_slot,
  input logic ev_byte,
  input logic ack_req,
  input logic busy,
  input logic unlocked
);

  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= busy ? run_q + 32'd1 : 32'd0;
  end

  // R2
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> $past(ev_byte));

  // R8
  no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ack_req);

  // R6
  busy_needs_slot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ev_stop && stop_in_slot));

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == 32'(WR_CYCLES)));

  // R9
  unlock_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(unlocked));

endmodule

bind pwd_present_seq pwd_present_seq_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_stop      (ev_stop),
  .stop_in_slot (stop_in_slot),
  .ev_byte      (ev_byte),
  .ack_req      (ack_req),
  .busy         (busy),
  .unlocked     (unlocked)
);

// File: tb/pwd_present_seq_tb.sv
module pwd_present_seq_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          W          = 10;
  localparam logic [31:0] GOOD       = 32'h1234ABCD;
  localparam logic [31:0] BAD        = 32'h1234ABCE;
  localparam logic [31:0] DIFF       = 32'h9234ABCD;
  localparam logic [31:0] REVERSED   = 32'hCDAB3412;

  typedef struct packed {
    logic [31:0] pw_a;
    logic [31:0] pw_b;
    logic [7:0]  vcode;
    logic        slot;
    logic        exp_busy;
    logic        exp_unl;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{GOOD, GOOD, 8'h09, 1'b1, 1'b1, 1'b1},
    '{BAD,  BAD,  8'h09, 1'b1, 1'b1, 1'b0},
    '{GOOD, GOOD, 8'h09, 1'b0, 1'b0, 1'b0},
    '{GOOD, DIFF, 8'h09, 1'b1, 1'b0, 1'b0},
    '{GOOD, GOOD, 8'h09, 1'b1, 1'b1, 1'b1},
    '{GOOD, DIFF, 8'h09, 1'b1, 1'b0, 1'b1},
    '{GOOD, GOOD, 8'h0A, 1'b1, 1'b0, 1'b1},
    '{BAD,  BAD,  8'h09, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_start = 1'b0;
  logic        ev_stop = 1'b0;
  logic        stop_in_slot = 1'b0;
  logic        ev_byte = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        ack_req, busy, unlocked;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwd_present_seq #(.WR_CYCLES(W)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .stop_in_slot (stop_in_slot),
    .ev_byte      (ev_byte),
    .byte_in      (byte_in),
    .pw_stored    (GOOD),
    .ack_req      (ack_req),
    .busy         (busy),
    .unlocked     (unlocked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk); byte_in = b; ev_byte = 1'b1;
    @(negedge clk); ev_byte = 1'b0;
    chk(tag, 32'(ack_req), 32'(exp_ack));
    repeat (2) @(negedge clk);
  endtask

  task automatic send_pw(input logic [31:0] pw, input logic exp_ack, input string tag);
    for (int i = 0; i < 4; i++) send_byte(pw[31-8*i -: 8], exp_ack, tag);
  endtask

  task automatic send_frame(input logic [31:0] pa, input logic [31:0] pb, input logic [7:0] vcode);
    logic ok;
    ok = (vcode == 8'h09);
    pulse_start();
    send_byte(8'hAE, 1'b1, "R2");
    send_byte(8'h09, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R2");
    send_pw(pa, 1'b1, "R2");
    send_byte(vcode, ok, ok ? "R2" : "R3");
    send_pw(pb, ok, ok ? "R2" : "R3");
  endtask

  task automatic stop_and_wait(input logic slot, input logic exp_busy, input logic exp_unl,
                               input string tag);
    int n;
    @(negedge clk); ev_stop = 1'b1; stop_in_slot = slot;
    @(negedge clk); ev_stop = 1'b0; stop_in_slot = 1'b0;
    chk(tag, 32'(busy), 32'(exp_busy));
    if (exp_busy) begin
      n = 0;
      while (busy && n < W + 4) begin
        n++;
        @(negedge clk);
      end
      chk("R7", 32'(n), 32'(W));
    end else begin
      repeat (3) @(negedge clk);
      chk(tag, 32'(busy), 32'd0);
    end
    chk(tag, 32'(unlocked), 32'(exp_unl));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'(ack_req), 32'd0);
    chk("R1", 32'(busy), 32'd0);
    chk("R1", 32'(unlocked), 32'd0);

    // Table walk: full frames with varied copies, codes and stop slots
    for (int v = 0; v < 8; v++) begin
      if (VECS[v].pw_a != VECS[v].pw_b)  tag = "R5";
      else if (VECS[v].vcode != 8'h09)   tag = "R3";
      else if (!VECS[v].slot)            tag = "R6";
      else                               tag = "R9";
      send_frame(VECS[v].pw_a, VECS[v].pw_b, VECS[v].vcode);
      stop_and_wait(VECS[v].slot, VECS[v].exp_busy, VECS[v].exp_unl, tag);
    end

    // R3: read/write bit set and chip-enable clear are rejected
    pulse_start();
    send_byte(8'hAF, 1'b0, "R3");
    send_byte(8'h09, 1'b0, "R3");
    pulse_start();
    send_byte(8'hA6, 1'b0, "R3");
    stop_and_wait(1'b1, 1'b0, 1'b0, "R3");

    // R10: repeated start mid-frame restarts at select stage
    pulse_start();
    send_byte(8'hAE, 1'b1, "R10");
    send_byte(8'h09, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    send_byte(8'h55, 1'b1, "R10");
    pulse_start();
    send_byte(8'h00, 1'b0, "R10");
    send_frame(GOOD, GOOD, 8'h09);
    stop_and_wait(1'b1, 1'b1, 1'b1, "R10");

    // R6: early stop, even in slot, does not launch
    pulse_start();
    send_byte(8'hAE, 1'b1, "R6");
    send_byte(8'h09, 1'b1, "R6");
    send_byte(8'h00, 1'b1, "R6");
    send_byte(8'h12, 1'b1, "R6");
    stop_and_wait(1'b1, 1'b0, 1'b1, "R6");

    // R11: extra byte after the second copy
    send_frame(BAD, BAD, 8'h09);
    send_byte(8'h00, 1'b0, "R11");
    stop_and_wait(1'b1, 1'b0, 1'b1, "R11");

    // R4: byte-reversed password must not match
    send_frame(REVERSED, REVERSED, 8'h09);
    stop_and_wait(1'b1, 1'b1, 1'b0, "R4");

    // R8: bus traffic during the internal cycle is ignored
    send_frame(GOOD, GOOD, 8'h09);
    @(negedge clk); ev_stop = 1'b1; stop_in_slot = 1'b1;
    @(negedge clk); ev_stop = 1'b0; stop_in_slot = 1'b0;
    chk("R8", 32'(busy), 32'd1);
    pulse_start();
    send_byte(8'hAE, 1'b0, "R8");
    chk("R8", 32'(busy), 32'd1);
    for (int k = 0; k < W + 4 && busy; k++) @(negedge clk);
    chk("R8", 32'(busy), 32'd0);
    chk("R8", 32'(unlocked), 32'd1);
    send_byte(8'h09, 1'b0, "R8");

    finish_run();
  end

endmodule